// File: doc/BRIEF.md
# Virtual Interface Hypervisor Control with Maintenance Interrupt

This block holds the 64-bit control word a hypervisor uses to steer the virtual interrupt CPU interface of one processing element. Software writes the word through a single-cycle write port, and the current contents are always visible on a read bus. The same contents feed a row of individual trap and mask outputs that other logic uses. The block also keeps a 5-bit wrapping count of deactivations that found no matching list-register entry.

The block watches the state fields of a parameterised set of list-register entries, the two virtual group-enable bits and the count. From these it evaluates several status conditions. Each condition has its own enable bit. The enabled conditions are ORed together and gated by the global interface enable, which gives one level-sensitive maintenance interrupt. This lets the hypervisor learn when it must refill or drain the list registers.

Top module: `vcpu_hyp_ctrl`

## Requirements
- R1: Bits 63:32, 26:16 and 9 of the control word always read as zero, and writes to them have no effect.
- R2: After synchronous reset every field, every trap output and the maintenance interrupt are zero.
- R3: Bit 0 drives `iface_en`. Bits 10 to 15 drive, in order, `trap_common`, `trap_grp0`, `trap_grp1`, `trap_sei`, `trap_dir` and `inject_mask`.
- R4: When bit 1 is set, the underflow condition holds while at most one entry is valid. An entry is valid when its 2-bit state field is nonzero. Entry i uses bits 2i+1:2i of `lr_state`.
- R5: Each cycle with `deact_miss` high and no write adds one to the count in bits 31:27. The count wraps from 31 to 0.
- R6: While bit 8 is set, a `deact_miss` with `deact_sgi` high leaves the count unchanged. A miss without `deact_sgi` still increments it.
- R7: When bit 2 is set, the entry-not-present condition holds while the count is nonzero.
- R8: A write in the same cycle as a counted miss loads the written bits 31:27 into the count, and the increment is lost.
- R9: When bit 3 is set, the no-pending condition holds while no entry has state 2'b01. State 2'b11 does not count as pending.
- R10: Bit 4 raises the interrupt while `grp0_vis` is 1, and bit 5 while it is 0. Bits 6 and 7 do the same for `grp1_vis`.
- R11: `maint_irq` is the OR of all enabled conditions, and it is forced low while bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write data |
| rd_data | output | 64 | Current control word |
| lr_state | input | 2*N_LR | State field of each list-register entry |
| grp0_vis | input | 1 | Virtual group 0 enable |
| grp1_vis | input | 1 | Virtual group 1 enable |
| deact_miss | input | 1 | Deactivation with no list-register entry |
| deact_sgi | input | 1 | Flags the miss as a virtual SGI |
| iface_en | output | 1 | Global virtual interface enable |
| trap_common | output | 1 | Common-register trap |
| trap_grp0 | output | 1 | Group 0 register trap |
| trap_grp1 | output | 1 | Group 1 register trap |
| trap_sei | output | 1 | Local SEI trap |
| trap_dir | output | 1 | Deactivate-register trap |
| inject_mask | output | 1 | Direct-injection mask |
| maint_irq | output | 1 | Maintenance interrupt level |

## Verification
The counter assertions treat `deact_miss` and `deact_sgi` as single-cycle samples. `deact_sgi` only has meaning while `deact_miss` is high. The stimulus drives each miss for exactly one clock and returns both lines low between events. `lr_state` and the group enables are assumed to be stable levels. The bench changes them only just after a clock edge and samples the interrupt a moment later, so the combinational status path is always settled when it is read.

// File: rtl/vhc_pkg.sv
package vhc_pkg;

    localparam int REG_W   = 64;
    localparam int CNT_W   = 5;
    localparam int CNT_LSB = 27;
    localparam int ST_W    = 2;

    typedef enum logic [ST_W-1:0] {
        LR_IDLE   = 2'b00,
        LR_PEND   = 2'b01,
        LR_ACT    = 2'b10,
        LR_PENDACT = 2'b11
    } lr_st_e;

    typedef struct packed {
        logic inj_mask;     // bit 15
        logic trap_dir;     // bit 14
        logic trap_sei;     // bit 13
        logic trap_grp1;    // bit 12
        logic trap_grp0;    // bit 11
        logic trap_common;  // bit 10
        logic sgi_nocount;  // bit 8
        logic g1_dis_ie;    // bit 7
        logic g1_en_ie;     // bit 6
        logic g0_dis_ie;    // bit 5
        logic g0_en_ie;     // bit 4
        logic nopend_ie;    // bit 3
        logic miss_ie;      // bit 2
        logic under_ie;     // bit 1
        logic enable;       // bit 0
    } ctl_t;

    typedef struct packed {
        logic under;
        logic miss;
        logic nopend;
        logic g0_en;
        logic g0_dis;
        logic g1_en;
        logic g1_dis;
    } cond_t;

    function automatic ctl_t word_to_ctl(input logic [REG_W-1:0] d);
        ctl_t c;
        c.enable      = d[0];
        c.under_ie    = d[1];
        c.miss_ie     = d[2];
        c.nopend_ie   = d[3];
        c.g0_en_ie    = d[4];
        c.g0_dis_ie   = d[5];
        c.g1_en_ie    = d[6];
        c.g1_dis_ie   = d[7];
        c.sgi_nocount = d[8];
        c.trap_common = d[10];
        c.trap_grp0   = d[11];
        c.trap_grp1   = d[12];
        c.trap_sei    = d[13];
        c.trap_dir    = d[14];
        c.inj_mask    = d[15];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_to_word(input ctl_t c,
                                                     input logic [CNT_W-1:0] n);
        logic [REG_W-1:0] w;
        w = '0;
        w[8:0]   = {c.sgi_nocount, c.g1_dis_ie, c.g1_en_ie, c.g0_dis_ie,
                    c.g0_en_ie, c.nopend_ie, c.miss_ie, c.under_ie, c.enable};
        w[15:10] = {c.inj_mask, c.trap_dir, c.trap_sei, c.trap_grp1,
                    c.trap_grp0, c.trap_common};
        w[CNT_LSB +: CNT_W] = n;
        return w;
    endfunction

endpackage

// File: rtl/vhc_ctlreg.sv
module vhc_ctlreg
    import vhc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 deact_miss,
    input  logic                 deact_sgi,
    output ctl_t                 ctl,
    output logic [CNT_W-1:0]     cnt
);

    logic count_evt;

    assign count_evt = deact_miss && !(deact_sgi && ctl.sgi_nocount);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            cnt <= '0;
        end else if (wr_en) begin
            ctl <= word_to_ctl(wr_data);
            cnt <= wr_data[CNT_LSB +: CNT_W];
        end else if (count_evt) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && deact_miss && !deact_sgi) |=> cnt == CNT_W'($past(cnt) + 1'b1)) // R5
        else $error("count did not step");

    AST_SGI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && deact_miss && deact_sgi && ctl.sgi_nocount) |=> $stable(cnt)) // R6
        else $error("SGI miss counted");

    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt == $past(wr_data[CNT_LSB +: CNT_W])) // R8
        else $error("write lost to increment");

endmodule

// File: rtl/vhc_lr_scan.sv
module vhc_lr_scan
    import vhc_pkg::*;
#(
    parameter int N_LR = 4
) (
    input  logic [N_LR*ST_W-1:0] lr_state,
    output logic                 under,
    output logic                 nopend
);

    localparam int VCNT_W = $clog2(N_LR + 1);

    logic [N_LR-1:0]   valid;
    logic [N_LR-1:0]   pend;
    logic [VCNT_W-1:0] nvalid;

    for (genvar i = 0; i < N_LR; i++) begin : g_ent
        lr_st_e st;
        assign st       = lr_st_e'(lr_state[i*ST_W +: ST_W]);
        assign valid[i] = (st != LR_IDLE);
        assign pend[i]  = (st == LR_PEND);
    end

    always_comb begin
        nvalid = '0;
        for (int i = 0; i < N_LR; i++) begin
            nvalid = nvalid + VCNT_W'(valid[i]);
        end
    end

    assign under  = (nvalid <= VCNT_W'(1));
    assign nopend = ~|pend;

endmodule

// File: rtl/vhc_maint.sv
module vhc_maint
    import vhc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic [CNT_W-1:0] cnt,
    input  logic             under,
    input  logic             nopend,
    input  logic             grp0_vis,
    input  logic             grp1_vis,
    output logic             irq
);

    cond_t act;

    always_comb begin
        act.under  = ctl.under_ie  && under;
        act.miss   = ctl.miss_ie   && (cnt != '0);
        act.nopend = ctl.nopend_ie && nopend;
        act.g0_en  = ctl.g0_en_ie  && grp0_vis;
        act.g0_dis = ctl.g0_dis_ie && !grp0_vis;
        act.g1_en  = ctl.g1_en_ie  && grp1_vis;
        act.g1_dis = ctl.g1_dis_ie && !grp1_vis;
    end

    assign irq = ctl.enable && (|act);

    AST_MISS_RAISES: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && ctl.miss_ie && cnt != '0) |-> irq) // R7
        else $error("miss condition did not raise irq");

endmodule

// File: rtl/vcpu_hyp_ctrl.sv
module vcpu_hyp_ctrl
    import vhc_pkg::*;
#(
    parameter int N_LR = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [63:0]          wr_data,
    output logic [63:0]          rd_data,
    input  logic [N_LR*2-1:0]    lr_state,
    input  logic                 grp0_vis,
    input  logic                 grp1_vis,
    input  logic                 deact_miss,
    input  logic                 deact_sgi,
    output logic                 iface_en,
    output logic                 trap_common,
    output logic                 trap_grp0,
    output logic                 trap_grp1,
    output logic                 trap_sei,
    output logic                 trap_dir,
    output logic                 inject_mask,
    output logic                 maint_irq
);

    ctl_t             ctl;
    logic [CNT_W-1:0] cnt;
    logic             under;
    logic             nopend;

    vhc_ctlreg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .deact_miss (deact_miss),
        .deact_sgi  (deact_sgi),
        .ctl        (ctl),
        .cnt        (cnt)
    );

    vhc_lr_scan #(.N_LR(N_LR)) u_scan (
        .lr_state (lr_state),
        .under    (under),
        .nopend   (nopend)
    );

    vhc_maint u_maint (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cnt      (cnt),
        .under    (under),
        .nopend   (nopend),
        .grp0_vis (grp0_vis),
        .grp1_vis (grp1_vis),
        .irq      (maint_irq)
    );

    assign rd_data     = ctl_to_word(ctl, cnt);
    assign iface_en    = ctl.enable;
    assign trap_common = ctl.trap_common;
    assign trap_grp0   = ctl.trap_grp0;
    assign trap_grp1   = ctl.trap_grp1;
    assign trap_sei    = ctl.trap_sei;
    assign trap_dir    = ctl.trap_dir;
    assign inject_mask = ctl.inj_mask;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[63:32] == '0) && (rd_data[26:16] == '0) && !rd_data[9]) // R1
        else $error("reserved bit set");

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        !rd_data[0] |-> !maint_irq) // R11
        else $error("irq while interface disabled");

endmodule

// File: tb/vcpu_hyp_ctrl_tb.sv
module vcpu_hyp_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_LR = 4;

    logic              clk = 0;
    logic              rst = 1;
    logic              wr_en = 0;
    logic [63:0]       wr_data = '0;
    logic [63:0]       rd_data;
    logic [N_LR*2-1:0] lr_state = '0;
    logic              grp0_vis = 0, grp1_vis = 0;
    logic              deact_miss = 0, deact_sgi = 0;
    logic              iface_en, trap_common, trap_grp0, trap_grp1;
    logic              trap_sei, trap_dir, inject_mask, maint_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcpu_hyp_ctrl #(.N_LR(N_LR)) u_dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [63:0] v);
        wr_en = 1; wr_data = v;
        tick();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic miss(input logic sgi);
        deact_miss = 1; deact_sgi = sgi;
        tick();
        deact_miss = 0; deact_sgi = 0;
    endtask

    function automatic logic [63:0] cw(input int n);
        return 64'(n) << 27;
    endfunction

    task automatic t_reset();
        chk("R2 word", rd_data, 64'h0);
        chk("R2 outs", {iface_en, trap_common, trap_grp0, trap_grp1, trap_sei,
                        trap_dir, inject_mask, maint_irq}, 64'h0);
    endtask

    task automatic t_reserved();
        wr('1);
        chk("R1 mask", rd_data, 64'h0000_0000_F800_FDFF);
        wr(64'hFFFF_FFFF_07FF_0200);
        chk("R1 only-reserved", rd_data, 64'h0);
    endtask

    task automatic t_traps();
        for (int k = 10; k < 16; k++) begin
            wr(64'h1 << k);
            chk("R3 trap", {58'h0, inject_mask, trap_dir, trap_sei, trap_grp1,
                            trap_grp0, trap_common}, 64'h1 << (k - 10));
        end
        wr(64'h1);
        chk("R3 iface_en", {63'h0, iface_en}, 64'h1);
    endtask

    task automatic t_under();
        wr(64'h3);
        lr_state = 8'b00_00_00_00; #1;
        chk("R4 none valid", {63'h0, maint_irq}, 64'h1);
        lr_state = 8'b00_00_10_00; #1;
        chk("R4 one valid", {63'h0, maint_irq}, 64'h1);
        lr_state = 8'b11_00_10_00; #1;
        chk("R4 two valid", {63'h0, maint_irq}, 64'h0);
        lr_state = '0;
    endtask

    task automatic t_nopend();
        wr(64'h9);
        lr_state = 8'b10_10_10_10; #1;
        chk("R9 none pending", {63'h0, maint_irq}, 64'h1);
        lr_state = 8'b10_01_10_10; #1;
        chk("R9 one pending", {63'h0, maint_irq}, 64'h0);
        lr_state = 8'b11_11_10_10; #1;
        chk("R9 pend+active", {63'h0, maint_irq}, 64'h1);
        lr_state = 8'b10_10_10_10;
    endtask

    task automatic t_count();
        wr(64'h5);
        chk("R7 zero count", {63'h0, maint_irq}, 64'h0);
        miss(0);
        chk("R5 one", rd_data, cw(1) | 64'h5);
        chk("R7 nonzero count", {63'h0, maint_irq}, 64'h1);
        for (int i = 0; i < 31; i++) miss(0);
        chk("R5 wrap", rd_data, 64'h5);
        chk("R7 wrapped", {63'h0, maint_irq}, 64'h0);
    endtask

    task automatic t_sgi();
        wr(64'h105);
        miss(1);
        chk("R6 sgi suppressed", rd_data, 64'h105);
        miss(0);
        chk("R6 non-sgi counted", rd_data, cw(1) | 64'h105);
        wr(cw(1) | 64'h5);
        miss(1);
        chk("R6 sgi counted when clear", rd_data, cw(2) | 64'h5);
    endtask

    task automatic t_wrwins();
        wr(cw(3) | 64'h5);
        wr_en = 1; wr_data = cw(10) | 64'h5; deact_miss = 1;
        tick();
        wr_en = 0; wr_data = '0; deact_miss = 0;
        chk("R8 write wins", rd_data, cw(10) | 64'h5);
    endtask

    task automatic t_groups();
        wr(64'h11);
        grp0_vis = 1; #1; chk("R10 g0 en on", {63'h0, maint_irq}, 64'h1);
        grp0_vis = 0; #1; chk("R10 g0 en off", {63'h0, maint_irq}, 64'h0);
        wr(64'h21);
        chk("R10 g0 dis", {63'h0, maint_irq}, 64'h1);
        wr(64'h41);
        grp1_vis = 1; #1; chk("R10 g1 en on", {63'h0, maint_irq}, 64'h1);
        wr(64'h81);
        chk("R10 g1 dis while on", {63'h0, maint_irq}, 64'h0);
        grp1_vis = 0; #1; chk("R10 g1 dis", {63'h0, maint_irq}, 64'h1);
    endtask

    task automatic t_gate();
        lr_state = '0;
        wr(64'hFE);
        chk("R11 gated off", {63'h0, maint_irq}, 64'h0);
        wr(64'hFF);
        chk("R11 gated on", {63'h0, maint_irq}, 64'h1);
    endtask

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        t_reset();
        t_reserved();
        t_traps();
        t_under();
        t_nopend();
        t_count();
        t_sgi();
        t_wrwins();
        t_groups();
        t_gate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule